// File: doc/BRIEF.md
# Selective Instruction Reuse Buffer

This block remembers the outcome of recently executed long-latency arithmetic operations (divide, multiply, square root) so that a later dynamic instance with the same program counter and the same operand values can take the stored result instead of occupying the execution unit again. Reuse is non-speculative. A lookup is made only once both operand values are known, and a hit is reported only when the stored operands equal the current ones. A hit can therefore never turn out to be wrong.

The buffer is set associative: 128 sets of 4 ways, 512 entries in total. Each entry holds an address tag, both operands and the result. A lookup presented in one cycle is answered on the registered outputs after the next clock edge. The execution unit writes completed eligible operations through a separate insert port. An insert whose tag is already present in the set rewrites that entry. Otherwise it fills a free way or replaces the least recently used one. Two running counters of eligible lookups and of hits let the reuse rate be derived.

Top module: `reuse_buffer`

## Requirements
- R1: While reset is held and just after it, `hit_o` is 0, `result_o` is 0 and both counters are 0.
- R2: An eligible lookup whose PC and both operands match a stored entry gives `hit_o`=1 and `result_o`= the stored result one clock edge later. When there is no hit, `result_o` is 0.
- R3: A lookup with a matching PC but a different value in either operand is a miss.
- R4: Class codes 1 (divide), 2 (multiply) and 3 (square root) are eligible. Lookups with any other class code never hit and are not counted. Inserts with any other class code store nothing, so a later eligible lookup with the same PC and operands misses.
- R5: The set index is `pc[6:0]` and the tag is `pc[31:7]`. Two PCs that share a set but differ in tag never hit on each other's entry.
- R6: An insert whose tag already sits in the set rewrites that entry in place. The old operands then miss, the new ones hit, and no other entry of the set is evicted.
- R7: A set holds up to 4 entries. An insert of a fifth distinct tag replaces the least recently used entry. Both a hit and an insert make an entry the most recently used.
- R8: When a valid eligible insert and a lookup address the same set in the same cycle, the insert is performed and the lookup is reported as a miss. A lookup to a different set in that cycle is unaffected.
- R9: `elig_cnt_o` advances by one for every eligible lookup, including one that loses to a same-set insert. `hit_cnt_o` advances by one for every reported hit. Both counters change on the same edge as `hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request with operands ready |
| lk_pc | input | 32 | Program counter of the looked-up operation |
| lk_class | input | 3 | Operation class code |
| lk_opa | input | 32 | First operand value |
| lk_opb | input | 32 | Second operand value |
| ins_valid | input | 1 | Completed operation to record |
| ins_pc | input | 32 | Program counter of the completed operation |
| ins_class | input | 3 | Class code of the completed operation |
| ins_opa | input | 32 | First operand of the completed operation |
| ins_opb | input | 32 | Second operand of the completed operation |
| ins_res | input | 32 | Result of the completed operation |
| hit_o | output | 1 | Registered reuse hit for the previous cycle's lookup |
| result_o | output | 32 | Reused result when `hit_o` is 1, else 0 |
| elig_cnt_o | output | 32 | Running count of eligible lookups |
| hit_cnt_o | output | 32 | Running count of reuse hits |

## Verification
A corrupted entry shows at the ports only on the first later lookup that addresses it. That lookup reports a false hit, a wrong `result_o` or a lost hit one edge after it is presented. Faulty recency ordering is subtler: it stays hidden until a fifth tag enters the set, and shows when a lookup to the wrongly kept or wrongly evicted entry follows. For that reason the stimulus repeatedly fills sets past their capacity and then looks up every tag. A reference model of each set, kept in recency order, predicts hit, result and both counters, and the bench compares them after every clock.

// File: rtl/reuse_buffer.sv
module reuse_buffer #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [2:0]        lk_class,
  input  logic [DATA_W-1:0] lk_opa,
  input  logic [DATA_W-1:0] lk_opb,
  input  logic              ins_valid,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [2:0]        ins_class,
  input  logic [DATA_W-1:0] ins_opa,
  input  logic [DATA_W-1:0] ins_opb,
  input  logic [DATA_W-1:0] ins_res,
  output logic              hit_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CNT_W-1:0]  elig_cnt_o,
  output logic [CNT_W-1:0]  hit_cnt_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic              vld_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] opa_q [SETS][WAYS];
  logic [DATA_W-1:0] opb_q [SETS][WAYS];
  logic [DATA_W-1:0] res_q [SETS][WAYS];
  logic [AGE_W-1:0]  age_q [SETS][WAYS];

  function automatic logic eligible(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
  endfunction

  logic [IDX_W-1:0] lk_set, ins_set;
  logic [TAG_W-1:0] lk_tag, ins_tag;
  logic             lk_elig, ins_go, collide, lk_hit;

  assign lk_set  = lk_pc[IDX_W-1:0];
  assign lk_tag  = lk_pc[PC_W-1:IDX_W];
  assign ins_set = ins_pc[IDX_W-1:0];
  assign ins_tag = ins_pc[PC_W-1:IDX_W];
  assign lk_elig = eligible(lk_class);
  assign ins_go  = ins_valid && eligible(ins_class);
  assign collide = ins_go && (ins_set == lk_set);

  logic              lk_any;
  logic [AGE_W-1:0]  lk_way;
  logic [DATA_W-1:0] lk_data;

  always_comb begin
    lk_any  = 1'b0;
    lk_way  = '0;
    lk_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag &&
          opa_q[lk_set][w] == lk_opa && opb_q[lk_set][w] == lk_opb) begin
        lk_any  = 1'b1;
        lk_way  = AGE_W'(w);
        lk_data = res_q[lk_set][w];
      end
    end
  end

  assign lk_hit = lk_valid && lk_elig && !collide && lk_any;

  logic             in_match, in_free;
  logic [AGE_W-1:0] m_way, f_way, o_way, ins_way;

  always_comb begin
    in_match = 1'b0;
    in_free  = 1'b0;
    m_way    = '0;
    f_way    = '0;
    o_way    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[ins_set][w] && tag_q[ins_set][w] == ins_tag) begin
        in_match = 1'b1;
        m_way    = AGE_W'(w);
      end
      if (!vld_q[ins_set][w] && !in_free) begin
        in_free = 1'b1;
        f_way   = AGE_W'(w);
      end
      if (age_q[ins_set][w] == OLDEST) o_way = AGE_W'(w);
    end
  end

  assign ins_way = in_match ? m_way : (in_free ? f_way : o_way);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= AGE_W'(w);
        end
    end else begin
      if (ins_go) begin
        vld_q[ins_set][ins_way] <= 1'b1;
        for (int w = 0; w < WAYS; w++)
          if (AGE_W'(w) == ins_way)
            age_q[ins_set][w] <= '0;
          else if (age_q[ins_set][w] < age_q[ins_set][ins_way])
            age_q[ins_set][w] <= age_q[ins_set][w] + 1'b1;
      end
      if (lk_hit) begin
        for (int w = 0; w < WAYS; w++)
          if (AGE_W'(w) == lk_way)
            age_q[lk_set][w] <= '0;
          else if (age_q[lk_set][w] < age_q[lk_set][lk_way])
            age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_go) begin
      tag_q[ins_set][ins_way] <= ins_tag;
      opa_q[ins_set][ins_way] <= ins_opa;
      opb_q[ins_set][ins_way] <= ins_opb;
      res_q[ins_set][ins_way] <= ins_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o      <= 1'b0;
      result_o   <= '0;
      elig_cnt_o <= '0;
      hit_cnt_o  <= '0;
    end else begin
      hit_o      <= lk_hit;
      result_o   <= lk_hit ? lk_data : '0;
      elig_cnt_o <= elig_cnt_o + CNT_W'(lk_valid && lk_elig);
      hit_cnt_o  <= hit_cnt_o + CNT_W'(lk_hit);
    end
  end
endmodule

module reuse_buffer_chk #(
  parameter int PC_W  = 32,
  parameter int SETS  = 128,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [PC_W-1:0]  lk_pc,
  input logic [2:0]       lk_class,
  input logic             ins_valid,
  input logic [PC_W-1:0]  ins_pc,
  input logic [2:0]       ins_class,
  input logic             hit_o,
  input logic [CNT_W-1:0] elig_cnt_o,
  input logic [CNT_W-1:0] hit_cnt_o
);
  localparam int IDX_W = $clog2(SETS);

  logic live_q;
  always_ff @(posedge clk) live_q <= rst_n;

  logic lk_e, in_e, same_set;
  assign lk_e     = lk_valid && lk_class != 3'd0 && lk_class <= 3'd3;
  assign in_e     = ins_valid && ins_class != 3'd0 && ins_class <= 3'd3;
  assign same_set = lk_pc[IDX_W-1:0] == ins_pc[IDX_W-1:0];

  // R4
  hit_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && hit_o) |-> $past(lk_e));

  // R8
  hit_no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && hit_o) |-> !$past(in_e && same_set));

  // R9
  elig_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> elig_cnt_o == $past(elig_cnt_o) + CNT_W'($past(lk_e)));

  // R9
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> hit_cnt_o == $past(hit_cnt_o) + CNT_W'(hit_o));

  // R9
  hits_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt_o <= elig_cnt_o);
endmodule

bind reuse_buffer reuse_buffer_chk #(.PC_W(PC_W), .SETS(SETS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_class(lk_class),
  .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_class(ins_class), .hit_o(hit_o),
  .elig_cnt_o(elig_cnt_o), .hit_cnt_o(hit_cnt_o)
);

// File: tb/reuse_buffer_tb.sv
module reuse_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, ins_valid = 1'b0;
  logic [31:0] lk_pc = '0, lk_opa = '0, lk_opb = '0;
  logic [31:0] ins_pc = '0, ins_opa = '0, ins_opb = '0, ins_res = '0;
  logic [2:0]  lk_class = '0, ins_class = '0;
  logic        hit_o;
  logic [31:0] result_o, elig_cnt_o, hit_cnt_o;

  always #10 clk = ~clk;

  reuse_buffer dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_class(lk_class), .lk_opa(lk_opa), .lk_opb(lk_opb),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_class(ins_class),
    .ins_opa(ins_opa), .ins_opb(ins_opb), .ins_res(ins_res),
    .hit_o(hit_o), .result_o(result_o), .elig_cnt_o(elig_cnt_o), .hit_cnt_o(hit_cnt_o)
  );

  typedef struct packed {
    logic [24:0] tag;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
  } ent_t;

  ent_t        mdl [128][$];
  int unsigned exp_elig = 0, exp_hits = 0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  function automatic bit elig(input logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input string rq,
                      input bit lv, input logic [31:0] lpc, input logic [2:0] lc,
                      input logic [31:0] la, input logic [31:0] lb,
                      input bit iv, input logic [31:0] ipc, input logic [2:0] ic,
                      input logic [31:0] ia, input logic [31:0] ib, input logic [31:0] ir);
    int sl, si, fi;
    bit eh;
    logic [31:0] er;
    ent_t e;
    lk_valid = lv; lk_pc = lpc; lk_class = lc; lk_opa = la; lk_opb = lb;
    ins_valid = iv; ins_pc = ipc; ins_class = ic; ins_opa = ia; ins_opb = ib; ins_res = ir;
    sl = int'(lpc[6:0]);
    si = int'(ipc[6:0]);
    eh = 0; er = '0;
    if (lv && elig(lc)) begin
      exp_elig++;
      if (!(iv && elig(ic) && si == sl)) begin
        fi = -1;
        for (int i = 0; i < mdl[sl].size(); i++)
          if (mdl[sl][i].tag == lpc[31:7] && mdl[sl][i].a == la && mdl[sl][i].b == lb) fi = i;
        if (fi >= 0) begin
          e = mdl[sl][fi];
          eh = 1; er = e.r;
          mdl[sl].delete(fi);
          mdl[sl].push_front(e);
          exp_hits++;
        end
      end
    end
    if (iv && elig(ic)) begin
      fi = -1;
      for (int i = 0; i < mdl[si].size(); i++)
        if (mdl[si][i].tag == ipc[31:7]) fi = i;
      if (fi >= 0) mdl[si].delete(fi);
      else if (mdl[si].size() == 4) void'(mdl[si].pop_back());
      e.tag = ipc[31:7]; e.a = ia; e.b = ib; e.r = ir;
      mdl[si].push_front(e);
    end
    @(posedge clk);
    @(negedge clk);
    chk(rq, "hit", {31'd0, hit_o}, {31'd0, eh});
    chk(rq, "result", result_o, er);
    chk("R9", "elig_cnt", elig_cnt_o, exp_elig);
    chk("R9", "hit_cnt", hit_cnt_o, exp_hits);
  endtask

  task automatic look(input string rq, input logic [31:0] pc, input logic [2:0] c,
                      input logic [31:0] a, input logic [31:0] b);
    step(rq, 1, pc, c, a, b, 0, '0, '0, '0, '0, '0);
  endtask

  task automatic put(input string rq, input logic [31:0] pc, input logic [2:0] c,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
    step(rq, 0, '0, '0, '0, '0, 1, pc, c, a, b, r);
  endtask

  function automatic logic [31:0] pcof(input int tag, input int set);
    return 32'(tag * 128 + set);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "hit in reset", {31'd0, hit_o}, 32'd0);
    chk("R1", "result in reset", result_o, 32'd0);
    chk("R1", "elig_cnt in reset", elig_cnt_o, 32'd0);
    chk("R1", "hit_cnt in reset", hit_cnt_o, 32'd0);
    rst_n = 1'b1;
    step("R1", 0, '0, '0, '0, '0, 0, '0, '0, '0, '0, '0);

    put("R2", pcof(2, 0), 3'd1, 32'd100, 32'd7, 32'd14);
    look("R2", pcof(2, 0), 3'd1, 32'd100, 32'd7);
    look("R3", pcof(2, 0), 3'd1, 32'd101, 32'd7);
    look("R3", pcof(2, 0), 3'd1, 32'd100, 32'd8);

    put("R4", pcof(3, 1), 3'd0, 32'd5, 32'd5, 32'd25);
    look("R4", pcof(3, 1), 3'd2, 32'd5, 32'd5);
    put("R4", pcof(3, 1), 3'd2, 32'd5, 32'd5, 32'd25);
    look("R4", pcof(3, 1), 3'd0, 32'd5, 32'd5);
    look("R4", pcof(3, 1), 3'd6, 32'd5, 32'd5);
    look("R4", pcof(3, 1), 3'd2, 32'd5, 32'd5);
    put("R4", pcof(4, 1), 3'd3, 32'd81, 32'd0, 32'd9);
    look("R4", pcof(4, 1), 3'd3, 32'd81, 32'd0);

    look("R5", pcof(3, 0), 3'd1, 32'd100, 32'd7);
    look("R5", pcof(2, 1), 3'd1, 32'd100, 32'd7);

    put("R6", pcof(2, 0), 3'd1, 32'd50, 32'd5, 32'd10);
    look("R6", pcof(2, 0), 3'd1, 32'd100, 32'd7);
    look("R6", pcof(2, 0), 3'd1, 32'd50, 32'd5);

    for (int t = 0; t < 4; t++) put("R7", pcof(t, 5), 3'd2, 32'(t), 32'd3, 32'(t * 3));
    look("R7", pcof(0, 5), 3'd2, 32'd0, 32'd3);
    put("R7", pcof(4, 5), 3'd2, 32'd4, 32'd3, 32'd12);
    for (int t = 0; t < 5; t++) look("R7", pcof(t, 5), 3'd2, 32'(t), 32'd3);
    put("R6", pcof(3, 5), 3'd2, 32'd9, 32'd9, 32'd81);
    for (int t = 0; t < 5; t++) look("R6", pcof(t, 5), 3'd2, 32'(t), 32'd3);

    step("R8", 1, pcof(0, 5), 3'd2, 32'd0, 32'd3, 1, pcof(7, 5), 3'd1, 32'd1, 32'd1, 32'd1);
    step("R8", 1, pcof(2, 0), 3'd1, 32'd50, 32'd5, 1, pcof(7, 5), 3'd1, 32'd2, 32'd2, 32'd4);
    step("R8", 1, pcof(2, 0), 3'd1, 32'd50, 32'd5, 1, pcof(9, 0), 3'd0, 32'd2, 32'd2, 32'd4);

    for (int k = 0; k < 600; k++) begin
      int s1 = ($urandom_range(0, 1) == 0) ? 5 : 9;
      int s2 = ($urandom_range(0, 1) == 0) ? 5 : 9;
      step("R7", $urandom_range(0, 3) != 0, pcof($urandom_range(0, 5), s1), 3'($urandom_range(0, 4)),
           32'($urandom_range(1, 2)), 32'($urandom_range(1, 2)),
           $urandom_range(0, 1) == 1, pcof($urandom_range(0, 5), s2), 3'($urandom_range(0, 4)),
           32'($urandom_range(1, 2)), 32'($urandom_range(1, 2)), $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule